// File: doc/BRIEF.md
# Four-Phase Handshake Sequencer

This block is a clocked control element that turns one incoming four-phase handshake into two outgoing four-phase handshakes run one after the other. A parent drives a request into the block and waits for the block's acknowledge. Between those two events the block acts as the active partner on two child channels: it first runs a full handshake on the first child, return to zero included, and then opens a handshake on the second child. The parent is acknowledged only once the second child has acknowledged.

The return-to-zero of the second child is tied to the return-to-zero of the parent. The second child's request is released only after the parent has dropped its request, and the parent's acknowledge falls only after the second child's acknowledge has fallen. Both return-to-zero phases therefore overlap. The block carries control only and has no data wires. It is written as a synchronous state machine. Its inputs are assumed to be already synchronised to the clock. Each output moves at the first clock edge at which the input it waits on has been seen.

Top module: `hs_sequencer`

## Requirements
- R1: While reset is high, and after it is released, every output (parentAck, firstReq, secondReq) is low until parentReq rises.
- R2: firstReq rises at the first clock edge that sees parentReq high in the idle state. It falls at the first edge that sees firstAck high.
- R3: secondReq rises only after firstReq is low and firstAck has returned low, at the first edge that sees firstAck low after it was high.
- R4: parentAck rises at the first edge that sees secondAck high, and never before.
- R5: secondReq stays high while parentReq is high. It falls at the first edge that sees parentReq low after parentAck has risen.
- R6: parentAck stays high until secondAck is seen low. It falls at that edge, and the block is then idle.
- R7: firstReq stays low for the whole time parentAck is high, so the first child sees no new request during the parent's return to zero.
- R8: Each output changes at most once per clock edge. Within one parent cycle the block's outputs follow exactly this order: firstReq up, firstReq down, secondReq up, parentAck up, secondReq down, parentAck down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| parentReq | input | 1 | Request from the parent (passive port) |
| parentAck | output | 1 | Acknowledge to the parent |
| firstReq | output | 1 | Request to the first child |
| firstAck | input | 1 | Acknowledge from the first child |
| secondReq | output | 1 | Request to the second child |
| secondAck | input | 1 | Acknowledge from the second child |

## Verification
The bench plays the parent and both children, with response delays drawn at random and zero-delay, back-to-back cycles included. After every input step it compares all three outputs with the vector expected for that phase. A design that raised the second request while the first acknowledge was still high would fail in the phase between the first child's two falling edges. A design that released the second request on its own acknowledge would show secondReq low while parentReq was still held high. A design that dropped parentAck early, or re-armed the first child during the parent's return to zero, would show a wrong vector in the phases where parentAck is high.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NUM_WIRES = 3;
  localparam int CH_FIRST  = 0;
  localparam int CH_SECOND = 1;
  localparam int CH_PARENT = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST_UP,
    ST_FIRST_RTZ,
    ST_SECOND_UP,
    ST_PARENT_ACK,
    ST_SECOND_RTZ
  } seqState_t;

  typedef struct packed {
    logic [NUM_WIRES-1:0] setWire;
    logic [NUM_WIRES-1:0] clrWire;
  } seqStrobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       parentReq,
  input  logic       firstAck,
  input  logic       secondAck,
  output seqStrobe_t strobe
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (parentReq) begin
        strobe.setWire[CH_FIRST] = 1'b1;
        stateNext = ST_FIRST_UP;
      end
      ST_FIRST_UP: if (firstAck) begin
        strobe.clrWire[CH_FIRST] = 1'b1;
        stateNext = ST_FIRST_RTZ;
      end
      ST_FIRST_RTZ: if (!firstAck) begin
        strobe.setWire[CH_SECOND] = 1'b1;
        stateNext = ST_SECOND_UP;
      end
      ST_SECOND_UP: if (secondAck) begin
        strobe.setWire[CH_PARENT] = 1'b1;
        stateNext = ST_PARENT_ACK;
      end
      ST_PARENT_ACK: if (!parentReq) begin
        strobe.clrWire[CH_SECOND] = 1'b1;
        stateNext = ST_SECOND_RTZ;
      end
      ST_SECOND_RTZ: if (!secondAck) begin
        strobe.clrWire[CH_PARENT] = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  AST_ONE_EDGE_PER_WIRE: assert property (@(posedge clk) disable iff (rst)
    (strobe.setWire & strobe.clrWire) == '0);                              // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({strobe.setWire, strobe.clrWire}) <= 1);                    // R8
endmodule

// File: rtl/seq_wires.sv
module seq_wires
  import seq_pkg::*;
#(
  parameter int WIDTH = NUM_WIRES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] setWire,
  input  logic [WIDTH-1:0] clrWire,
  output logic [WIDTH-1:0] wireQ
);
  for (genvar i = 0; i < WIDTH; i++) begin : gWire
    always_ff @(posedge clk) begin
      if (rst)             wireQ[i] <= 1'b0;
      else if (setWire[i]) wireQ[i] <= 1'b1;
      else if (clrWire[i]) wireQ[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/hs_sequencer.sv
module hs_sequencer
  import seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic parentReq,
  output logic parentAck,
  output logic firstReq,
  input  logic firstAck,
  output logic secondReq,
  input  logic secondAck
);
  seqStrobe_t           strobe;
  logic [NUM_WIRES-1:0] wireQ;

  seq_ctrl uCtrl (
    .clk(clk), .rst(rst), .parentReq(parentReq),
    .firstAck(firstAck), .secondAck(secondAck), .strobe(strobe)
  );

  seq_wires #(.WIDTH(NUM_WIRES)) uWires (
    .clk(clk), .rst(rst), .setWire(strobe.setWire),
    .clrWire(strobe.clrWire), .wireQ(wireQ)
  );

  assign firstReq  = wireQ[CH_FIRST];
  assign secondReq = wireQ[CH_SECOND];
  assign parentAck = wireQ[CH_PARENT];

  AST_FIRST_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(firstReq) |-> $past(firstAck));                                   // R2
  AST_FIRST_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(firstReq) |-> $past(parentReq));                                  // R2
  AST_FIRST_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(secondReq) |-> !firstReq && !$past(firstAck));                    // R3
  AST_ACK_AFTER_SECOND: assert property (@(posedge clk) disable iff (rst)
    $rose(parentAck) |-> $past(secondAck));                                 // R4
  AST_SECOND_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(secondReq) |-> !$past(parentReq));                                // R5
  AST_ACK_RTZ: assert property (@(posedge clk) disable iff (rst)
    $fell(parentAck) |-> !$past(secondAck));                                // R6
  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    parentAck |-> !firstReq);                                               // R7
endmodule

// File: tb/hs_sequencer_test.sv
module hs_sequencer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic parentReq = 1'b0, firstAck = 1'b0, secondAck = 1'b0;
  logic parentAck, firstReq, secondReq;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  hs_sequencer uut (
    .clk(clk), .rst(rst), .parentReq(parentReq), .parentAck(parentAck),
    .firstReq(firstReq), .firstAck(firstAck),
    .secondReq(secondReq), .secondAck(secondAck)
  );

  // Expected {parentAck, secondReq, firstReq} per phase of one parent cycle.
  function automatic logic [2:0] expOut(int phase);
    case (phase)
      1: return 3'b001;
      2: return 3'b000;
      3: return 3'b010;
      4: return 3'b110;
      5: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(string req, int phase);
    logic [2:0] act;
    act = {parentAck, secondReq, firstReq};
    checks++;
    if (act !== expOut(phase)) begin
      errors++;
      $display("FAIL %s phase %0d actual %b expected %b", req, phase, act, expOut(phase));
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hold(string req, int phase, int maxDelay);
    int d;
    d = $urandom_range(0, maxDelay);
    for (int i = 0; i < d; i++) begin
      step();
      chk(req, phase);
    end
  endtask

  task automatic cycle(int maxDelay);
    parentReq = 1'b1; step(); chk("R2", 1);
    hold("R2", 1, maxDelay);
    firstAck = 1'b1;  step(); chk("R2", 2);
    hold("R3", 2, maxDelay);
    firstAck = 1'b0;  step(); chk("R3", 3);
    hold("R4", 3, maxDelay);
    secondAck = 1'b1; step(); chk("R4", 4);
    hold("R5_R7", 4, maxDelay);
    parentReq = 1'b0; step(); chk("R5", 5);
    hold("R6_R7", 5, maxDelay);
    secondAck = 1'b0; step(); chk("R6", 0);
    hold("R8", 0, maxDelay);
  endtask

  initial begin
    void'($urandom(32'h5EED_0001));
    @(negedge clk);
    chk("R1", 0);
    step(); step();
    chk("R1", 0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R1", 0);
    end
    cycle(0);
    cycle(0);
    for (int n = 0; n < 40; n++) cycle(6);
    cycle(0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule